// File: doc/BRIEF.md
# Four-Region Buck-Boost Switch Sequencer

This block drives the five gate enables of a non-inverting buck-boost power stage. The stage has a buck leg (high side and low side), a boost leg (high side and low side) and a series switch that stops reverse conduction from the output. The converter always runs in forced continuous conduction. Each switching period is split into an energising phase and a free-wheeling phase. There is no skipped or idle period. A switching-clock pulse opens every period. Two digitised current comparator flags end the variable phase: one flag marks the valley threshold and the other marks the peak threshold.

From digitised input and output voltage codes, the block picks one of four regions. It classifies by integer comparison at a ratio of 6/5, with a programmable hysteresis band. Deep buck and deep boost modulate one leg and hold the other still. The two transition regions alternate buck and boost periods. The non-modulated period of each pair has a fixed programmable length. The block stops all switching when the input is above a fixed overvoltage code. It also stops when the input is below the larger of a fixed internal undervoltage code and a programmable enable threshold. It then waits for a fresh period start before it switches again.

Top module: `bbsw_sequencer`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises, all five switch enables are low and `region` reads 0.
- R2: The regions are encoded as 0 = buck (6·vout < 5·vin), 1 = buck-transition (5·vin < 6·vout and vout < vin), 2 = boost-transition (vin < vout and 5·vout < 6·vin) and 3 = boost (5·vout > 6·vin). `region` shows the region that was taken at the latest period start.
- R3: For each of the three boundaries, the scaled difference must be above +hyst to cross upward and below −hyst to cross back. Inside the band, the previous side is kept.
- R4: In region 0 every period is a buck period. The boost high side stays on. The buck low side is on from the period start until the valley flag is seen, and then the buck high side is on until the next start. The peak flag has no effect.
- R5: In region 3 every period is a boost period. The buck high side stays on. The boost low side is on until the peak flag is seen, and then the boost high side is on. The valley flag has no effect.
- R6: In region 1, buck periods that end on the valley flag alternate with boost periods. In a boost period of this region, the boost low side is requested for exactly `ton_fix` clocks from the start, and then the boost high side takes over.
- R7: In region 2, boost periods that end on the peak flag alternate with buck periods. In a buck period of this region, the buck low side is requested for exactly `toff_fix` clocks, and then the buck high side takes over.
- R8: The region changes only at a period start. In a transition region, the region is not re-evaluated until the second period of the buck/boost pair has begun, so the pair always finishes.
- R9: The high and low enables of one leg are never on together. On every change between them, both stay off for `dead_cnt`+1 clocks.
- R10: If `vin_code` > OVP_CODE, the blocking switch turns off and all leg enables are low one clock later. An input equal to OVP_CODE keeps running.
- R11: The same shutdown happens if `vin_code` is below max(UVI_CODE, `uv_prog`). An input equal to that maximum keeps running.
- R12: After a shutdown clears, all five enables stay low until the next `cyc_start`. The block then resumes in the region evaluated at that moment, with the blocking switch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that opens a switching period |
| valley_hit | input | 1 | Inductor current has reached the valley threshold |
| peak_hit | input | 1 | Inductor current has reached the peak threshold |
| vin_code | input | W | Digitised input voltage |
| vout_code | input | W | Digitised output voltage |
| uv_prog | input | W | Programmable enable/undervoltage threshold |
| hyst | input | W | Hysteresis band for the region boundaries |
| ton_fix | input | CW | Fixed boost low-side length in region 1, in clocks |
| toff_fix | input | CW | Fixed buck low-side length in region 2, in clocks |
| dead_cnt | input | CW | Dead time, both enables off for this value plus one clocks |
| buck_hi | output | 1 | Buck leg high-side enable |
| buck_lo | output | 1 | Buck leg low-side enable |
| boost_hi | output | 1 | Boost leg high-side enable |
| boost_lo | output | 1 | Boost leg low-side enable |
| block_on | output | 1 | Reverse-blocking switch enable |
| region | output | 2 | Region taken at the latest period start |

## Verification
Output codes are stepped across each region with the input fixed at 480. This shows that every boundary lands on the right side of its 6/5 or unity ratio. Codes just inside and just past the hysteresis band on the unity boundary separate a held region from a crossed one. In each region, the flag that should end the phase and the flag that should not are pulsed one at a time. Clock-exact samples around the fixed-length phases and a leg swap pin down the `ton_fix`/`toff_fix` counts and the dead time. A region change requested in the middle of a pair shows that the pair finishes before the new region is used. Input codes above, at and below the overvoltage and both undervoltage limits separate the strict and non-strict comparisons.

// File: rtl/bbsw_pkg.sv
// Shared types for the buck-boost switch sequencer.
// Assumes: region codes are visible at the top ports and their order matters
// (popcount of the boundary flags gives the region number).
package bbsw_pkg;

    typedef enum logic [1:0] {
        RG_BUCK     = 2'd0,
        RG_BUCK_TR  = 2'd1,
        RG_BOOST_TR = 2'd2,
        RG_BOOST    = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;

    typedef enum logic [1:0] {
        ST_SHUT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_e;

    typedef enum logic {
        CY_BUCK  = 1'b0,
        CY_BOOST = 1'b1
    } cyc_e;

endpackage

// File: rtl/bbsw_region_cls.sv
// Region classifier. It compares three scaled differences of the output and
// input codes against a +/-hyst band and keeps one sticky flag per boundary.
// The region number is the number of flags that are set.
// Assumes: W-bit unsigned codes; the target region is registered (1 clock).
module bbsw_region_cls
    import bbsw_pkg::*;
#(
    parameter int W = 10
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vin,
    input  logic [W-1:0] vout,
    input  logic [W-1:0] hyst,
    output region_e      target
);
    localparam int DW = W + 5;

    logic signed [DW-1:0] vo_s, vi_s, hy_s;
    logic [2:0] above;

    assign vo_s = signed'(DW'(vout));
    assign vi_s = signed'(DW'(vin));
    assign hy_s = signed'(DW'(hyst));

    for (genvar i = 0; i < 3; i++) begin : g_bnd
        // boundary 0: 6*vout vs 5*vin, 1: vout vs vin, 2: 5*vout vs 6*vin
        localparam int KO = (i == 0) ? 6 : ((i == 1) ? 1 : 5);
        localparam int KI = (i == 0) ? 5 : ((i == 1) ? 1 : 6);
        logic signed [DW-1:0] diff;
        logic up;

        assign diff = DW'(KO * vo_s - KI * vi_s);

        // sticky side flag with hysteresis band around zero
        always_ff @(posedge clk) begin
            if (!rst_n)           up <= 1'b0;
            else if (diff > hy_s) up <= 1'b1;
            else if (diff < -hy_s) up <= 1'b0;
        end

        assign above[i] = up;
    end

    assign target = region_e'(2'($countones(above)));

endmodule

// File: rtl/bbsw_guard.sv
// Input supply guard. It requests shutdown when the input code is above the
// overvoltage limit or below the larger of the two undervoltage limits.
// Assumes: one registered clock of latency; the guard reads shut during reset.
module bbsw_guard #(
    parameter int W        = 10,
    parameter int OVP_CODE = 760,
    parameter int UVI_CODE = 210
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vin,
    input  logic [W-1:0] uv_prog,
    output logic         shut
);
    logic [W-1:0] floor_code;

    // effective undervoltage floor: the larger of fixed and programmed
    always_comb begin
        floor_code = (uv_prog > W'(UVI_CODE)) ? uv_prog : W'(UVI_CODE);
    end

    // register the shutdown request
    always_ff @(posedge clk) begin
        if (!rst_n) shut <= 1'b1;
        else        shut <= (vin > W'(OVP_CODE)) || (vin < floor_code);
    end

endmodule

// File: rtl/bbsw_leg.sv
// Half-bridge leg driver with dead time. It follows the requested leg state.
// Whenever the applied state leaves HI or LO, it first goes OFF, waits dead+1
// clocks and then applies the new request.
// Assumes: the outputs are registered and can never be HI and LO at once.
module bbsw_leg
    import bbsw_pkg::*;
#(
    parameter int CW = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  leg_e          want,
    input  logic [CW-1:0] dead,
    output logic          hi,
    output logic          lo
);
    leg_e          app;
    logic [CW-1:0] cnt;

    // applied state and dead-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app <= LEG_OFF;
            cnt <= '0;
        end else if (want != app) begin
            if (app != LEG_OFF) begin
                app <= LEG_OFF;
                cnt <= dead;
            end else if (cnt == '0) begin
                app <= want;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign hi = (app == LEG_HI);
    assign lo = (app == LEG_LO);

endmodule

// File: rtl/bbsw_sequencer.sv
// Four-region buck-boost switch sequencer (top). At each period start it takes
// a region. A transition pair is never split. In each period it runs a first
// phase (low side of the modulated leg), which ends on a flag or on a fixed
// count, and then a second phase on the high side. Two leg drivers add the
// dead time.
// Assumes: cyc_start is a one-clock pulse; the flags are synchronous to clk.
module bbsw_sequencer
    import bbsw_pkg::*;
#(
    parameter int W        = 10,
    parameter int CW       = 8,
    parameter int OVP_CODE = 760,
    parameter int UVI_CODE = 210
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          valley_hit,
    input  logic          peak_hit,
    input  logic [W-1:0]  vin_code,
    input  logic [W-1:0]  vout_code,
    input  logic [W-1:0]  uv_prog,
    input  logic [W-1:0]  hyst,
    input  logic [CW-1:0] ton_fix,
    input  logic [CW-1:0] toff_fix,
    input  logic [CW-1:0] dead_cnt,
    output logic          buck_hi,
    output logic          buck_lo,
    output logic          boost_hi,
    output logic          boost_lo,
    output logic          block_on,
    output logic [1:0]    region
);
    localparam int NLEG = 2;

    region_e       tgt, act_rg, take_rg;
    seq_st_e       st;
    cyc_e          kind, start_kind;
    logic          first, pair_open, pair_next, shut;
    logic          fixed_ph, end_first;
    logic [CW-1:0] tmr, lim, lim_m1;
    leg_e          want [NLEG];
    logic [NLEG-1:0] hi_v, lo_v;

    bbsw_region_cls #(.W(W)) u_cls (
        .clk(clk), .rst_n(rst_n), .vin(vin_code), .vout(vout_code),
        .hyst(hyst), .target(tgt)
    );

    bbsw_guard #(.W(W), .OVP_CODE(OVP_CODE), .UVI_CODE(UVI_CODE)) u_guard (
        .clk(clk), .rst_n(rst_n), .vin(vin_code), .uv_prog(uv_prog),
        .shut(shut)
    );

    // choice made at a period start: region, period kind, pair bookkeeping
    always_comb begin
        take_rg = pair_open ? act_rg : tgt;
        unique case (take_rg)
            RG_BUCK:     start_kind = CY_BUCK;
            RG_BOOST:    start_kind = CY_BOOST;
            RG_BUCK_TR:  start_kind = pair_open ? CY_BOOST : CY_BUCK;
            default:     start_kind = pair_open ? CY_BUCK : CY_BOOST;
        endcase
        pair_next = (take_rg == RG_BUCK_TR || take_rg == RG_BOOST_TR) && !pair_open;
    end

    // end of the first phase: fixed count in the transition half, else flag
    always_comb begin
        fixed_ph = (act_rg == RG_BUCK_TR  && kind == CY_BOOST) ||
                   (act_rg == RG_BOOST_TR && kind == CY_BUCK);
        lim      = (kind == CY_BOOST) ? ton_fix : toff_fix;
        lim_m1   = (lim == '0) ? '0 : lim - 1'b1;
        if (fixed_ph)              end_first = (tmr >= lim_m1);
        else if (kind == CY_BUCK)  end_first = valley_hit;
        else                       end_first = peak_hit;
    end

    // sequencer state: shutdown, armed, running period and phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_SHUT;
            act_rg    <= RG_BUCK;
            kind      <= CY_BUCK;
            first     <= 1'b1;
            pair_open <= 1'b0;
            tmr       <= '0;
        end else if (shut) begin
            st        <= ST_SHUT;
            pair_open <= 1'b0;
        end else begin
            unique case (st)
                ST_SHUT: st <= ST_ARM;
                default: begin
                    if (cyc_start) begin
                        st        <= ST_RUN;
                        act_rg    <= take_rg;
                        kind      <= start_kind;
                        first     <= 1'b1;
                        tmr       <= '0;
                        pair_open <= pair_next;
                    end else if (st == ST_RUN && first) begin
                        if (end_first) first <= 1'b0;
                        else           tmr   <= tmr + 1'b1;
                    end
                end
            endcase
        end
    end

    // leg requests: index 0 is the buck leg, index 1 the boost leg
    always_comb begin
        want[0] = LEG_OFF;
        want[1] = LEG_OFF;
        if (st == ST_RUN) begin
            if (kind == CY_BUCK) begin
                want[0] = first ? LEG_LO : LEG_HI;
                want[1] = LEG_HI;
            end else begin
                want[0] = LEG_HI;
                want[1] = first ? LEG_LO : LEG_HI;
            end
        end
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        bbsw_leg #(.CW(CW)) u_leg (
            .clk(clk), .rst_n(rst_n), .want(want[g]), .dead(dead_cnt),
            .hi(hi_v[g]), .lo(lo_v[g])
        );
    end

    assign buck_hi  = hi_v[0];
    assign buck_lo  = lo_v[0];
    assign boost_hi = hi_v[1];
    assign boost_lo = lo_v[1];
    assign block_on = (st == ST_RUN);
    assign region   = act_rg;

endmodule

// File: rtl/bbsw_sequencer_chk.sv
// Port-level checker for bbsw_sequencer: leg exclusion, dead gap, shutdown
// forcing, restart on a period start and region hold between starts.
module bbsw_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic       buck_hi,
    input logic       buck_lo,
    input logic       boost_hi,
    input logic       boost_lo,
    input logic       block_on,
    input logic [1:0] region
);
    AST_BUCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(buck_hi && buck_lo)); // R9
    AST_BOOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(boost_hi && boost_lo)); // R9
    AST_BUCK_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n) $rose(buck_lo) |-> !$past(buck_hi)); // R9
    AST_BUCK_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n) $rose(buck_hi) |-> !$past(buck_lo)); // R9
    AST_BOOST_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n) $rose(boost_lo) |-> !$past(boost_hi)); // R9
    AST_BOOST_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n) $rose(boost_hi) |-> !$past(boost_lo)); // R9
    AST_LEGS_OFF_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) !block_on |=> !(buck_hi || buck_lo || boost_hi || boost_lo)); // R10
    AST_RESUME_ON_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(block_on) |-> $past(cyc_start)); // R12
    AST_REGION_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cyc_start |=> $stable(region)); // R8
endmodule

bind bbsw_sequencer bbsw_sequencer_chk u_chk (.*);

// File: tb/bbsw_sequencer_test.sv
`timescale 1ns/1ps
module bbsw_sequencer_test;
    localparam int W = 10;
    localparam int CW = 8;
    localparam logic [6:0] M_BLK = 7'b1000000;
    localparam logic [6:0] M_RG  = 7'b0110000;
    localparam logic [6:0] M_BKH = 7'b0001000;
    localparam logic [6:0] M_BKL = 7'b0000100;
    localparam logic [6:0] M_BSH = 7'b0000010;
    localparam logic [6:0] M_BSL = 7'b0000001;
    localparam logic [6:0] M_LEG = 7'b0001111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, valley_hit = 1'b0, peak_hit = 1'b0;
    logic [W-1:0] vin_code = 10'd480, vout_code = 10'd200, uv_prog = '0, hyst = 10'd4;
    logic [CW-1:0] ton_fix = 8'd5, toff_fix = 8'd5, dead_cnt = 8'd1;
    logic buck_hi, buck_lo, boost_hi, boost_lo, block_on;
    logic [1:0] region;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [6:0] mask;
        logic [6:0] val;
        string      tag;
    } item_t;
    item_t sb[$];
    event pushed;

    always #2.5 clk = ~clk;

    bbsw_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .valley_hit(valley_hit),
        .peak_hit(peak_hit), .vin_code(vin_code), .vout_code(vout_code),
        .uv_prog(uv_prog), .hyst(hyst), .ton_fix(ton_fix), .toff_fix(toff_fix),
        .dead_cnt(dead_cnt), .buck_hi(buck_hi), .buck_lo(buck_lo),
        .boost_hi(boost_hi), .boost_lo(boost_lo), .block_on(block_on), .region(region)
    );

    function automatic logic [6:0] rgv(input int r);
        return 7'(r << 4);
    endfunction

    // driver side: queue one expected observation at the current negedge
    task automatic expect_o(input logic [6:0] mask, input logic [6:0] val, input string tag);
        item_t it;
        it.mask = mask;
        it.val = val;
        it.tag = tag;
        sb.push_back(it);
        ->pushed;
        #0;
    endtask

    // monitor side: pop and compare against the live outputs
    initial begin
        forever begin
            @(pushed);
            while (sb.size() > 0) begin
                item_t it;
                logic [6:0] obs;
                it = sb.pop_front();
                obs = {block_on, region, buck_hi, buck_lo, boost_hi, boost_lo};
                n_chk++;
                if ((obs & it.mask) !== (it.val & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b (mask %b)", it.tag,
                             obs & it.mask, it.val & it.mask, it.mask);
                end
            end
        end
    end

    task automatic waitn(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic start_pulse();
        @(negedge clk) cyc_start = 1'b1;
        @(negedge clk) cyc_start = 1'b0;
    endtask

    task automatic valley_pulse();
        @(negedge clk) valley_hit = 1'b1;
        @(negedge clk) valley_hit = 1'b0;
    endtask

    task automatic peak_pulse();
        @(negedge clk) peak_hit = 1'b1;
        @(negedge clk) peak_hit = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        waitn(3);
        expect_o(M_BLK | M_RG | M_LEG, 7'b0, "R1 outputs in reset");
        @(negedge clk) rst_n = 1'b1;
        waitn(4);
        expect_o(M_BLK | M_RG | M_LEG, 7'b0, "R1 R12 armed idle after reset");

        // buck region
        start_pulse();
        expect_o(M_BLK | M_RG, M_BLK | rgv(0), "R2 R4 buck region taken");
        waitn(3);
        expect_o(M_LEG, M_BKL | M_BSH, "R4 buck low with boost high");
        valley_pulse();
        waitn(1);
        expect_o(M_BKH | M_BKL, 7'b0, "R9 dead gap clock 1");
        waitn(1);
        expect_o(M_BKH | M_BKL, 7'b0, "R9 dead gap clock 2");
        waitn(1);
        expect_o(M_LEG, M_BKH | M_BSH, "R4 R9 buck high after gap");
        start_pulse();
        waitn(4);
        expect_o(M_LEG, M_BKL | M_BSH, "R4 buck low at period start");
        peak_pulse();
        waitn(4);
        expect_o(M_LEG, M_BKL | M_BSH, "R4 peak ignored in buck");
        valley_pulse();
        waitn(4);

        // boost region
        vout_code = 10'd700;
        waitn(3);
        start_pulse();
        waitn(4);
        expect_o(M_BLK | M_RG | M_LEG, M_BLK | rgv(3) | M_BSL | M_BKH, "R2 R5 boost low with buck high");
        valley_pulse();
        waitn(4);
        expect_o(M_LEG, M_BSL | M_BKH, "R5 valley ignored in boost");
        peak_pulse();
        waitn(4);
        expect_o(M_LEG, M_BSH | M_BKH, "R5 boost high after peak");

        // buck-transition region
        vout_code = 10'd440;
        waitn(3);
        start_pulse();
        waitn(4);
        expect_o(M_RG | M_LEG, rgv(1) | M_BKL | M_BSH, "R2 R6 buck half of pair");
        valley_pulse();
        waitn(4);
        expect_o(M_LEG, M_BKH | M_BSH, "R6 buck high after valley");
        start_pulse();
        waitn(5);
        expect_o(M_LEG, M_BSL | M_BKH, "R6 boost low at last fixed clock");
        waitn(1);
        expect_o(M_BSL | M_BSH, 7'b0, "R6 boost low ends after ton_fix");
        waitn(2);
        expect_o(M_LEG, M_BSH | M_BKH, "R6 boost high after fixed on-time");
        start_pulse();
        waitn(4);
        expect_o(M_LEG, M_BKL | M_BSH, "R6 alternates back to buck");

        // region request inside an open pair
        vout_code = 10'd700;
        waitn(3);
        valley_pulse();
        waitn(4);
        start_pulse();
        expect_o(M_RG, rgv(1), "R8 region held for second half");
        waitn(5);
        expect_o(M_BSL, M_BSL, "R8 second half is fixed boost");
        waitn(3);
        start_pulse();
        expect_o(M_RG, rgv(3), "R8 region taken after pair");

        // boost-transition region
        vout_code = 10'd520;
        waitn(3);
        start_pulse();
        waitn(4);
        expect_o(M_RG | M_LEG, rgv(2) | M_BSL | M_BKH, "R2 R7 boost half of pair");
        peak_pulse();
        waitn(4);
        expect_o(M_LEG, M_BSH | M_BKH, "R7 boost high after peak");
        start_pulse();
        waitn(5);
        expect_o(M_LEG, M_BKL | M_BSH, "R7 buck low at last fixed clock");
        waitn(1);
        expect_o(M_BKL | M_BKH, 7'b0, "R7 buck low ends after toff_fix");
        waitn(2);
        expect_o(M_LEG, M_BKH | M_BSH, "R7 buck high after fixed off-time");

        // hysteresis on the unity boundary
        vout_code = 10'd478;
        waitn(3);
        start_pulse();
        expect_o(M_RG, rgv(2), "R3 inside band keeps region");
        waitn(3);
        start_pulse();
        waitn(3);
        vout_code = 10'd470;
        waitn(3);
        start_pulse();
        expect_o(M_RG, rgv(1), "R3 past band crosses down");

        // overvoltage
        vin_code = 10'd800;
        waitn(5);
        expect_o(M_BLK | M_LEG, 7'b0, "R10 overvoltage stops switching");
        vin_code = 10'd480;
        waitn(6);
        expect_o(M_BLK | M_LEG, 7'b0, "R12 idle until period start");
        start_pulse();
        expect_o(M_BLK | M_RG, M_BLK | rgv(1), "R12 resumes in fresh region");
        waitn(4);
        expect_o(M_LEG, M_BKL | M_BSH, "R12 fresh period switching");
        vin_code = 10'd760;
        waitn(5);
        expect_o(M_BLK, M_BLK, "R10 equal to limit keeps running");

        // undervoltage, programmable and internal
        uv_prog = 10'd400;
        vin_code = 10'd380;
        waitn(5);
        expect_o(M_BLK | M_LEG, 7'b0, "R11 below programmed floor stops");
        vin_code = 10'd400;
        waitn(5);
        expect_o(M_BLK | M_LEG, 7'b0, "R12 armed after floor clears");
        start_pulse();
        expect_o(M_BLK, M_BLK, "R11 equal to programmed floor runs");
        uv_prog = 10'd0;
        vin_code = 10'd200;
        waitn(5);
        expect_o(M_BLK | M_LEG, 7'b0, "R11 below internal floor stops");
        vin_code = 10'd210;
        waitn(5);
        start_pulse();
        expect_o(M_BLK, M_BLK, "R11 equal to internal floor runs");

        waitn(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule